// File: doc/BRIEF.md
# Programmable Chip-Select Decode Array

This block turns the address, port pins, page register, read strobe and reset pin of a small microcontroller system into active-high select lines. It drives eight memory-block selects, a RAM select, a select for a 256-byte internal-register window, and two peripheral-mode selects for a port's peripheral I/O mode. Each select is a programmable product term: a value/mask pair over a 45-bit decode vector. The pairs are written through a simple configuration port. Memory block 7 is the one select built from two OR-ed terms, so it can answer in two separate address windows, for example a main window and a vector area. Inside the register window, a sub-decoder turns the low address byte into a one-hot strobe for each register.

The address field comes from `bus_addr[15:0]` in the normal mode and from `bus_addr[19:4]` in the wide-bus mode. With turbo on, the outputs follow the inputs after one clock. With turbo off, decode takes one more clock. An idle counter then sends the array to standby after `IDLE_CYCLES` clocks with no input change. In standby the outputs are frozen. When several selects match at once they all assert, with no priority, and an overlap flag reports it.

Top module: `csel_decode_array`

## Requirements
- R1: The decode vector is {reset_pin[44], rd_strobe[43], page_reg[42:39], port_c_pins[38:32], port_b[31:24], port_a[23:16], address field[15:0]}. A term hits when ((vector XOR value) AND mask) is zero. Every select output is active high.
- R2: A term whose mask is all zero is disabled and never hits, whatever the input.
- R3: Term index map: 0–7 are memory blocks 0–7, 8 is the second term of memory block 7, 9 is RAM, 10 is the register window, and 11–12 are peripheral selects 0–1. `mem_sel[7]` is the OR of terms 7 and 8.
- R4: With `wide_addr_mode`=1 the address field is `bus_addr[19:4]`. With `wide_addr_mode`=0 it is `bus_addr[15:0]`.
- R5: `reg_strobe[i]` is high only when `regwin_sel` is high and address field bits [7:0] equal i. At most one strobe is high at a time, and an offset at or above REG_COUNT raises none.
- R6: While vector bit 44 (`reset_pin`) is high, every select, strobe and the overlap flag are low, regardless of the term contents.
- R7: When two or more of the twelve select outputs are high, all of them stay high and `overlap` is high. Otherwise `overlap` is low.
- R8: With `turbo_en`=1 the outputs reflect an input change one clock edge later. With `turbo_en`=0 they reflect it two clock edges later.
- R9: With `turbo_en`=0, `asleep` rises after IDLE_CYCLES clocks with no change in the decode vector. While asleep, the outputs are held, and configuration writes do not show until an input change wakes the array. With `turbo_en`=1, `asleep` stays low.
- R10: A write with `cfg_we`=1 loads the value and mask into term `cfg_idx`. An index of 13 or above is ignored. `rst_n` low clears every term, so no select asserts afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset; clears terms and outputs |
| cfg_we | input | 1 | Term write enable |
| cfg_idx | input | 4 | Term index to write |
| cfg_value | input | 45 | Match value for the term |
| cfg_mask | input | 45 | Care mask for the term (1 = compare) |
| turbo_en | input | 1 | 1 = fast decode with no standby; 0 = low-power decode |
| wide_addr_mode | input | 1 | Selects bus_addr[19:4] as the address field |
| bus_addr | input | 20 | Microcontroller address bus |
| port_a | input | 8 | Port A pins |
| port_b | input | 8 | Port B pins |
| port_c_pins | input | 7 | Port C pins 7..3 (bits 6:2) and 1..0 (bits 1:0) |
| page_reg | input | 4 | Page register |
| rd_strobe | input | 1 | Read control bit |
| reset_pin | input | 1 | Reset pin as a decode input; forces selects low |
| mem_sel | output | 8 | Memory-block selects |
| ram_sel | output | 1 | RAM select |
| regwin_sel | output | 1 | Internal-register window select |
| periph_sel | output | 2 | Peripheral-mode selects |
| reg_strobe | output | REG_COUNT | One-hot register strobes inside the window |
| overlap | output | 1 | Two or more selects are high together |
| asleep | output | 1 | Array is in standby |

## Verification
The hardest state to reach is standby with a configuration change pending. The bench holds every decode input steady in low-power mode for longer than the idle interval, then disables a term that is currently hitting. It checks that the select stays high, because the held outputs hide the new configuration. A single address bit is then flipped to wake the array, and the bench checks that the disabled term's select drops two edges later. The bench also writes to index 13, whose low three bits alias memory block 5, to show that out-of-range writes are dropped.

// File: rtl/csel_pkg.sv
package csel_pkg;
   localparam int ADDR_W     = 16;
   localparam int PORTA_W    = 8;
   localparam int PORTB_W    = 8;
   localparam int PORTC_W    = 7;
   localparam int PAGE_W     = 4;
   localparam int VEC_W      = ADDR_W + PORTA_W + PORTB_W + PORTC_W + PAGE_W + 2;
   localparam int RD_BIT     = VEC_W - 2;
   localparam int RST_BIT    = VEC_W - 1;
   localparam int NUM_TERMS  = 13;
   localparam int TERM_IDX_W = $clog2(NUM_TERMS);
   localparam int NUM_SEL    = 12;
   // select vector positions
   localparam int SEL_RAM    = 8;
   localparam int SEL_WIN    = 9;
   localparam int SEL_PER0   = 10;
   // term positions
   localparam int T_MEM7B    = 8;
   localparam int T_RAM      = 9;
   localparam int T_WIN      = 10;
   localparam int T_PER0     = 11;

   typedef logic [VEC_W-1:0] dvec_t;

   typedef struct packed {
      dvec_t value;
      dvec_t mask;
   } term_t;
endpackage

// File: rtl/csel_term_bank.sv
module csel_term_bank
   import csel_pkg::*;
#(
   parameter int TERMS = NUM_TERMS,
   parameter int IDX_W = TERM_IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [IDX_W-1:0] cfg_idx,
   input  dvec_t            cfg_value,
   input  dvec_t            cfg_mask,
   input  dvec_t            eval_vec,
   output logic [TERMS-1:0] hit
);
   if (TERMS > (1 << IDX_W)) begin : g_bad_idx
      $error("csel_term_bank: index width too small for term count");
   end

   for (genvar i = 0; i < TERMS; i++) begin : g_term
      term_t store_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            store_q <= '0;
         end else if (cfg_we && (cfg_idx == IDX_W'(i))) begin
            store_q.value <= cfg_value;
            store_q.mask  <= cfg_mask;
         end
      end

      always_comb begin
         hit[i] = (|store_q.mask) &&
                  (((eval_vec ^ store_q.value) & store_q.mask) == '0);
      end
   end
endmodule

// File: rtl/csel_idle_mon.sv
module csel_idle_mon
   import csel_pkg::*;
#(
   parameter int IDLE_CYCLES = 8
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  turbo_en,
   input  dvec_t cur_vec,
   output dvec_t prev_vec,
   output logic  standby
);
   localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(IDLE_CYCLES);

   if (IDLE_CYCLES < 1) begin : g_bad_idle
      $error("csel_idle_mon: IDLE_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] idle_cnt_q;
   logic             changed;

   assign changed = (cur_vec != prev_vec);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_vec   <= '0;
         idle_cnt_q <= '0;
      end else begin
         prev_vec <= cur_vec;
         if (changed) begin
            idle_cnt_q <= '0;
         end else if (idle_cnt_q != CNT_TOP) begin
            idle_cnt_q <= idle_cnt_q + 1'b1;
         end
      end
   end

   assign standby = !turbo_en && (idle_cnt_q == CNT_TOP);

   AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      changed |=> (idle_cnt_q == '0)); // R9
endmodule

// File: rtl/csel_reg_subdec.sv
module csel_reg_subdec #(
   parameter int REG_COUNT = 16
) (
   input  logic                 win_sel,
   input  logic [7:0]           offset,
   output logic [REG_COUNT-1:0] strobe
);
   if (REG_COUNT < 1 || REG_COUNT > 256) begin : g_bad_count
      $error("csel_reg_subdec: REG_COUNT must be 1..256");
   end

   for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
      assign strobe[i] = win_sel && (offset == 8'(i));
   end
endmodule

// File: rtl/csel_decode_array.sv
module csel_decode_array
   import csel_pkg::*;
#(
   parameter int IDLE_CYCLES = 8,
   parameter int REG_COUNT   = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [3:0]            cfg_idx,
   input  logic [44:0]           cfg_value,
   input  logic [44:0]           cfg_mask,
   input  logic                  turbo_en,
   input  logic                  wide_addr_mode,
   input  logic [19:0]           bus_addr,
   input  logic [7:0]            port_a,
   input  logic [7:0]            port_b,
   input  logic [6:0]            port_c_pins,
   input  logic [3:0]            page_reg,
   input  logic                  rd_strobe,
   input  logic                  reset_pin,
   output logic [7:0]            mem_sel,
   output logic                  ram_sel,
   output logic                  regwin_sel,
   output logic [1:0]            periph_sel,
   output logic [REG_COUNT-1:0]  reg_strobe,
   output logic                  overlap,
   output logic                  asleep
);
   if (VEC_W != 45 || TERM_IDX_W != 4) begin : g_bad_pkg
      $error("csel_decode_array: package widths do not match port widths");
   end

   logic [ADDR_W-1:0]    addr_field;
   dvec_t                cur_vec;
   dvec_t                prev_vec;
   dvec_t                eval_vec;
   logic                 standby;
   logic [NUM_TERMS-1:0] hit;
   logic [NUM_SEL-1:0]   sel_d;
   logic [NUM_SEL-1:0]   sel_q;
   logic [REG_COUNT-1:0] strobe_d;
   logic [REG_COUNT-1:0] strobe_q;
   logic                 overlap_q;

   // address source picked by bus mode
   assign addr_field = wide_addr_mode ? bus_addr[19:4] : bus_addr[ADDR_W-1:0];
   assign cur_vec    = {reset_pin, rd_strobe, page_reg, port_c_pins,
                        port_b, port_a, addr_field};

   csel_idle_mon #(.IDLE_CYCLES(IDLE_CYCLES)) idle_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .turbo_en (turbo_en),
      .cur_vec  (cur_vec),
      .prev_vec (prev_vec),
      .standby  (standby)
   );

   // turbo evaluates the live inputs, low-power mode one stage behind
   assign eval_vec = turbo_en ? cur_vec : prev_vec;

   csel_term_bank #(.TERMS(NUM_TERMS), .IDX_W(TERM_IDX_W)) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_idx   (cfg_idx),
      .cfg_value (cfg_value),
      .cfg_mask  (cfg_mask),
      .eval_vec  (eval_vec),
      .hit       (hit)
   );

   always_comb begin
      sel_d = '0;
      if (!eval_vec[RST_BIT]) begin
         sel_d[6:0]      = hit[6:0];
         sel_d[7]        = hit[7] | hit[T_MEM7B];
         sel_d[SEL_RAM]  = hit[T_RAM];
         sel_d[SEL_WIN]  = hit[T_WIN];
         sel_d[SEL_PER0 +: 2] = hit[T_PER0 +: 2];
      end
   end

   csel_reg_subdec #(.REG_COUNT(REG_COUNT)) subdec_i (
      .win_sel (sel_d[SEL_WIN]),
      .offset  (eval_vec[7:0]),
      .strobe  (strobe_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q     <= '0;
         strobe_q  <= '0;
         overlap_q <= 1'b0;
      end else if (!standby) begin
         sel_q     <= sel_d;
         strobe_q  <= strobe_d;
         overlap_q <= ($countones(sel_d) > 1);
      end
   end

   assign mem_sel    = sel_q[7:0];
   assign ram_sel    = sel_q[SEL_RAM];
   assign regwin_sel = sel_q[SEL_WIN];
   assign periph_sel = sel_q[SEL_PER0 +: 2];
   assign reg_strobe = strobe_q;
   assign overlap    = overlap_q;
   assign asleep     = standby;

   AST_RST_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!standby && eval_vec[RST_BIT]) |=> (sel_q == '0 && strobe_q == '0)); // R6
   AST_HOLD_IN_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> ($stable(sel_q) && $stable(strobe_q))); // R9
   AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(strobe_q)); // R5
   AST_STROBE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (|strobe_q) |-> sel_q[SEL_WIN]); // R5
   AST_OVERLAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      overlap_q |-> ($countones(sel_q) >= 2)); // R7
   AST_MEM7_SECOND_TERM: assert property (@(posedge clk) disable iff (!rst_n)
      (!standby && !eval_vec[RST_BIT] && hit[T_MEM7B]) |=> sel_q[7]); // R3
endmodule

// File: tb/csel_decode_array_tb_top.sv
`timescale 1ns/1ps
module csel_decode_array_tb_top;
   localparam int IDLE = 8;
   localparam int REGS = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_idx = '0;
   logic [44:0] cfg_value = '0;
   logic [44:0] cfg_mask = '0;
   logic        turbo_en = 1'b1;
   logic        wide_addr_mode = 1'b0;
   logic [19:0] bus_addr = '0;
   logic [7:0]  port_a = '0;
   logic [7:0]  port_b = '0;
   logic [6:0]  port_c_pins = '0;
   logic [3:0]  page_reg = '0;
   logic        rd_strobe = 1'b0;
   logic        reset_pin = 1'b0;
   logic [7:0]  mem_sel;
   logic        ram_sel;
   logic        regwin_sel;
   logic [1:0]  periph_sel;
   logic [REGS-1:0] reg_strobe;
   logic        overlap;
   logic        asleep;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 0;

   logic [44:0] sh_val [13];
   logic [44:0] sh_msk [13];

   always #4 clk = ~clk;

   csel_decode_array #(.IDLE_CYCLES(IDLE), .REG_COUNT(REGS)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_value(cfg_value), .cfg_mask(cfg_mask), .turbo_en(turbo_en),
      .wide_addr_mode(wide_addr_mode), .bus_addr(bus_addr), .port_a(port_a),
      .port_b(port_b), .port_c_pins(port_c_pins), .page_reg(page_reg),
      .rd_strobe(rd_strobe), .reset_pin(reset_pin), .mem_sel(mem_sel),
      .ram_sel(ram_sel), .regwin_sel(regwin_sel), .periph_sel(periph_sel),
      .reg_strobe(reg_strobe), .overlap(overlap), .asleep(asleep)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [44:0] cur_vec();
      logic [15:0] a;
      a = wide_addr_mode ? bus_addr[19:4] : bus_addr[15:0];
      return {reset_pin, rd_strobe, page_reg, port_c_pins, port_b, port_a, a};
   endfunction

   function automatic logic [11:0] model_sel(input logic [44:0] v);
      logic [12:0] h;
      for (int i = 0; i < 13; i++)
         h[i] = (sh_msk[i] != '0) && (((v ^ sh_val[i]) & sh_msk[i]) == '0);
      if (v[44]) return '0;
      return {h[12:11], h[10], h[9], h[7] | h[8], h[6:0]};
   endfunction

   function automatic logic [11:0] got_sel();
      return {periph_sel, regwin_sel, ram_sel, mem_sel};
   endfunction

   task automatic clear_shadow();
      for (int i = 0; i < 13; i++) begin
         sh_val[i] = '0;
         sh_msk[i] = '0;
      end
   endtask

   task automatic cfg_write(input int idx, input logic [44:0] v, input logic [44:0] m);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_value = v; cfg_mask = m;
      @(negedge clk);
      cfg_we = 1'b0;
      if (idx < 13) begin
         sh_val[idx] = v;
         sh_msk[idx] = m;
      end
   endtask

   function automatic logic [44:0] aterm(input logic [15:0] a);
      return {29'd0, a};
   endfunction

   task automatic set_addr(input logic [19:0] a);
      @(negedge clk);
      bus_addr = a;
   endtask

   task automatic settle(input int edges);
      repeat (edges) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_all(input string req);
      logic [11:0] es;
      logic [REGS-1:0] est;
      logic [44:0] v;
      v = cur_vec();
      es = model_sel(v);
      est = '0;
      if (es[9] && v[7:0] < REGS) est[v[7:0]] = 1'b1;
      check(got_sel() == es, req, 64'(got_sel()), 64'(es));
      check(reg_strobe == est, req, 64'(reg_strobe), 64'(est));
      check(overlap == ($countones(es) > 1), req, 64'(overlap), 64'($countones(es) > 1));
   endtask

   task automatic go(input logic [19:0] a, input string req);
      set_addr(a);
      settle(2);
      check_all(req);
   endtask

   task automatic t_reset_state();
      check(got_sel() == '0 && reg_strobe == '0 && !overlap && !asleep,
            "R10 reset state", 64'({got_sel(), reg_strobe, overlap, asleep}), 64'd0);
   endtask

   task automatic t_basic_decode();
      cfg_write(0, aterm(16'h0000), aterm(16'hF000));
      cfg_write(1, aterm(16'h1000), aterm(16'hF000));
      cfg_write(9, {2'b01, 27'd0, 16'h2000}, {2'b01, 27'd0, 16'hF000});
      cfg_write(10, aterm(16'h3000), aterm(16'hFF00));
      cfg_write(11, {29'd1 << 7, 16'h4000}, {29'd1 << 7, 16'hF000});
      go(20'h00123, "R1 mem0 hit");
      go(20'h01FFF, "R1 mem1 hit");
      go(20'h09000, "R1 no hit");
      @(negedge clk); rd_strobe = 1'b0;
      go(20'h02004, "R1 ram needs read low->no hit");
      @(negedge clk); rd_strobe = 1'b1;
      go(20'h02004, "R1 ram with read");
      check(ram_sel == 1'b1, "R1 ram_sel", 64'(ram_sel), 64'd1);
      @(negedge clk); rd_strobe = 1'b0; port_a = 8'h00;
      go(20'h04000, "R1 periph0 port bit low");
      check(periph_sel[0] == 1'b0, "R1 periph0 off", 64'(periph_sel), 64'd0);
      @(negedge clk); port_a = 8'h80;
      go(20'h04000, "R1 periph0 port bit high");
      check(periph_sel[0] == 1'b1, "R1 periph0 on", 64'(periph_sel), 64'd1);
      @(negedge clk); port_a = 8'h00;
   endtask

   task automatic t_disabled_term();
      cfg_write(3, '1, '0);
      go(20'h0FFFF, "R2 zero mask never hits");
      check(mem_sel[3] == 1'b0, "R2 mem3 stays low", 64'(mem_sel), 64'd0);
      @(negedge clk); port_a = 8'hFF; port_b = 8'hFF; page_reg = 4'hF;
      go(20'h0FFFF, "R2 zero mask all-ones input");
      check(mem_sel[3] == 1'b0, "R2 mem3 low all ones", 64'(mem_sel), 64'd0);
      @(negedge clk); port_a = 8'h00; port_b = 8'h00; page_reg = 4'h0;
   endtask

   task automatic t_dual_window();
      cfg_write(7, aterm(16'h7000), aterm(16'hF000));
      cfg_write(8, aterm(16'hFFF0), aterm(16'hFFF0));
      go(20'h07ABC, "R3 first window");
      check(mem_sel[7] == 1'b1, "R3 mem7 first", 64'(mem_sel), 64'h80);
      go(20'h0FFF8, "R3 second window");
      check(mem_sel[7] == 1'b1, "R3 mem7 second", 64'(mem_sel), 64'h80);
      go(20'h0FF00, "R3 neither window");
      check(mem_sel[7] == 1'b0, "R3 mem7 off", 64'(mem_sel), 64'h00);
   endtask

   task automatic t_wide_mode();
      @(negedge clk); wide_addr_mode = 1'b1;
      go(20'h10000, "R4 wide field");
      check(mem_sel[1:0] == 2'b10, "R4 wide picks 19:4", 64'(mem_sel), 64'h02);
      @(negedge clk); wide_addr_mode = 1'b0;
      go(20'h10000, "R4 narrow field");
      check(mem_sel[1:0] == 2'b01, "R4 narrow picks 15:0", 64'(mem_sel), 64'h01);
   endtask

   task automatic t_strobes();
      go(20'h03005, "R5 strobe 5");
      check(reg_strobe == REGS'(1 << 5), "R5 one-hot 5", 64'(reg_strobe), 64'(1 << 5));
      go(20'h0300F, "R5 strobe top");
      go(20'h030FF, "R5 offset beyond count");
      check(reg_strobe == '0 && regwin_sel, "R5 none beyond", 64'(reg_strobe), 64'd0);
      go(20'h02005, "R5 outside window");
      check(reg_strobe == '0, "R5 none outside", 64'(reg_strobe), 64'd0);
   endtask

   task automatic t_reset_pin();
      @(negedge clk); reset_pin = 1'b1;
      go(20'h03003, "R6 reset pin forces low");
      check(got_sel() == '0 && reg_strobe == '0, "R6 all low",
            64'({got_sel(), reg_strobe}), 64'd0);
      @(negedge clk); reset_pin = 1'b0;
      go(20'h03003, "R6 released");
   endtask

   task automatic t_overlap();
      cfg_write(12, aterm(16'h0000), aterm(16'hF000));
      go(20'h00010, "R7 overlap");
      check(overlap && mem_sel[0] && periph_sel[1], "R7 both assert",
            64'({overlap, mem_sel[0], periph_sel[1]}), 64'h7);
      go(20'h01010, "R7 no overlap");
      check(!overlap, "R7 flag clear", 64'(overlap), 64'd0);
   endtask

   task automatic t_latency();
      logic [11:0] old_s;
      go(20'h00000, "R8 turbo prep");
      set_addr(20'h01000);
      settle(1);
      check(mem_sel == 8'h02, "R8 turbo one edge", 64'(mem_sel), 64'h02);
      @(negedge clk); turbo_en = 1'b0;
      go(20'h00000, "R8 slow prep");
      old_s = got_sel();
      set_addr(20'h01000);
      settle(1);
      check(got_sel() == old_s, "R8 slow not yet", 64'(got_sel()), 64'(old_s));
      settle(1);
      check(mem_sel == 8'h02, "R8 slow two edges", 64'(mem_sel), 64'h02);
   endtask

   task automatic t_standby();
      go(20'h01000, "R9 prep");
      settle(IDLE + 3);
      check(asleep == 1'b1, "R9 asleep after idle", 64'(asleep), 64'd1);
      cfg_write(1, '0, '0);
      settle(3);
      check(mem_sel[1] == 1'b1, "R9 held while asleep", 64'(mem_sel), 64'h02);
      set_addr(20'h01001);
      settle(2);
      check(asleep == 1'b0, "R9 woke", 64'(asleep), 64'd0);
      check(mem_sel[1] == 1'b0, "R9 new config after wake", 64'(mem_sel), 64'h00);
      @(negedge clk); turbo_en = 1'b1;
      settle(IDLE + 4);
      check(asleep == 1'b0, "R9 turbo never asleep", 64'(asleep), 64'd0);
   endtask

   task automatic t_cfg_index();
      cfg_write(13, aterm(16'h5000), aterm(16'hF000));
      go(20'h05000, "R10 index 13 ignored");
      check(mem_sel[5] == 1'b0, "R10 no alias to mem5", 64'(mem_sel), 64'h00);
      go(20'h00000, "R10 before sys reset");
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      clear_shadow();
      settle(2);
      check(got_sel() == '0, "R10 terms cleared", 64'(got_sel()), 64'd0);
   endtask

   initial begin
      clear_shadow();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle(2);
      t_reset_state();
      t_basic_decode();
      t_disabled_term();
      t_dual_window();
      t_wide_mode();
      t_strobes();
      t_reset_pin();
      t_overlap();
      t_latency();
      t_standby();
      t_cfg_index();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule